// File: doc/BRIEF.md
# Body-Bias Mode Transition Sequencer

This block sits beside one macro and turns a level-sensitive sleep request from the power manager into three ordered control strobes for that macro's body-bias amplifier. The strobes are an amplifier enable, a reverse-bias clamp enable and a short pull-to-ground pulse. Every change of the request starts a fixed sequence, and every strobe change is spaced by a programmable number of clock cycles. The sequence is break-before-make: the amplifier is always released before the clamp engages, and the clamp is always released before the ground pull begins. The amplifier comes back only after the pull has ended.

The pull pulse ends when the macro's body-at-ground indication is sampled high, or when a cycle timeout expires, whichever comes first. An optional synchroniser on that indication is chosen by a parameter. A stable output is high only when the macro rests fully active or fully in standby, so the power manager can tell when a request has taken effect. Once a sequence has started it always runs to its end. If the request has flipped in the meantime, the opposite sequence starts right after it.

Top module: `bbias_seq`

## Requirements
- R1: While reset is held, and at reset release, the clamp is high, the amplifier enable and pull are low, and stable is high. The macro rests in standby.
- R2: From rest in active, the amplifier enable drops on the first clock edge that samples sleep_req high. The clamp rises GAP_CYCLES edges later. Both are low in between.
- R3: The pull strobe is low throughout the active-to-standby sequence and for the whole standby rest.
- R4: From rest in standby, the clamp drops on the first clock edge that samples sleep_req low. The pull rises GAP_CYCLES edges later.
- R5: The pull stays high for at least one cycle. It falls on the edge that samples the (optionally synchronised) body indication high while the pull is high, and in any case after at most WAKE_TIMEOUT cycles.
- R6: The amplifier enable rises GAP_CYCLES edges after the pull falls, with all three strobes low in between.
- R7: The clamp is never high together with the pull, and never high together with the amplifier enable.
- R8: A change of sleep_req during a sequence does not alter that sequence. The opposite sequence begins on the first edge after the rest state is reached.
- R9: stable is high only at the active rest (amplifier on, others off) or the standby rest (clamp on, others off). It is low in every intermediate step.
- R10: body_at_gnd has no effect outside the pull pulse, both at either rest and during the release step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset, forces standby rest |
| sleep_req | input | 1 | Level request from the power manager: 1 = standby, 0 = active |
| body_at_gnd | input | 1 | Indication that the macro body has reached ground |
| amp_en_o | output | 1 | Bias amplifier enable |
| rbb_clamp_o | output | 1 | Large reverse-bias clamp enable |
| body_pull_o | output | 1 | Pull-to-ground pulse |
| stable_o | output | 1 | High only at the active or standby rest |

## Verification
On every cycle the assertions check the mutual exclusion of the clamp with the pull and with the amplifier, the break-before-make order at each strobe edge, the bound on the pull pulse length, and that stable appears only with one of the two rest patterns. Only the bench's scenarios show the exact cycle on which each strobe moves. They also show that a flipped request waits for the running sequence to finish, that the body indication is ignored at rest and during release, and that a reset taken while active returns the macro to standby at once.

// File: rtl/bbias_seq_pkg.sv
package bbias_seq_pkg;

   typedef enum logic [2:0] {
      ST_ACTIVE  = 3'd0,
      ST_AMP_OFF = 3'd1,
      ST_STANDBY = 3'd2,
      ST_RELEASE = 3'd3,
      ST_PULL    = 3'd4,
      ST_SETTLE  = 3'd5
   } seq_state_e;

   typedef struct packed {
      logic amp_en;
      logic clamp;
      logic pull;
      logic stable;
   } strobe_t;

   function automatic strobe_t strobes_of(seq_state_e s);
      strobe_t o;
      o = '0;
      case (s)
         ST_ACTIVE:  begin o.amp_en = 1'b1; o.stable = 1'b1; end
         ST_STANDBY: begin o.clamp  = 1'b1; o.stable = 1'b1; end
         ST_PULL:    o.pull = 1'b1;
         default:    o = '0;
      endcase
      return o;
   endfunction

endpackage

// File: rtl/bbias_step_timer.sv
module bbias_step_timer #(
   parameter int GAP_CYCLES   = 1,
   parameter int WAKE_TIMEOUT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic gap_done,
   output logic tmo_done
);
   localparam int MAX_CNT = (GAP_CYCLES > WAKE_TIMEOUT) ? GAP_CYCLES : WAKE_TIMEOUT;
   localparam int CW      = $clog2(MAX_CNT + 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt_q <= '0;
      else if (restart)                   cnt_q <= '0;
      else if (cnt_q != CW'(MAX_CNT - 1)) cnt_q <= cnt_q + 1'b1;
   end

   assign gap_done = (cnt_q == CW'(GAP_CYCLES - 1));
   assign tmo_done = (cnt_q == CW'(WAKE_TIMEOUT - 1));

endmodule

// File: rtl/bbias_seq_fsm.sv
module bbias_seq_fsm
   import bbias_seq_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    sleep_req,
   input  logic    settled_seen,
   input  logic    gap_done,
   input  logic    tmo_done,
   output logic    restart,
   output strobe_t strobes
);
   seq_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_ACTIVE:  if (sleep_req)                 state_d = ST_AMP_OFF;
         ST_AMP_OFF: if (gap_done)                  state_d = ST_STANDBY;
         ST_STANDBY: if (!sleep_req)                state_d = ST_RELEASE;
         ST_RELEASE: if (gap_done)                  state_d = ST_PULL;
         ST_PULL:    if (settled_seen || tmo_done)  state_d = ST_SETTLE;
         ST_SETTLE:  if (gap_done)                  state_d = ST_ACTIVE;
         default:                                   state_d = ST_STANDBY;
      endcase
   end

   assign restart = (state_d != state_q);

   // Strobes come straight from flops loaded with the next state's pattern.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_STANDBY;
         strobes <= strobes_of(ST_STANDBY);
      end else begin
         state_q <= state_d;
         strobes <= strobes_of(state_d);
      end
   end

endmodule

// File: rtl/bbias_seq.sv
module bbias_seq
   import bbias_seq_pkg::*;
#(
   parameter int GAP_CYCLES   = 1,
   parameter int WAKE_TIMEOUT = 4,
   parameter int SYNC_STAGES  = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sleep_req,
   input  logic body_at_gnd,
   output logic amp_en_o,
   output logic rbb_clamp_o,
   output logic body_pull_o,
   output logic stable_o
);
   if (GAP_CYCLES < 1) begin : g_bad_gap
      $error("GAP_CYCLES must be at least 1");
   end
   if (WAKE_TIMEOUT < 1) begin : g_bad_tmo
      $error("WAKE_TIMEOUT must be at least 1");
   end
   if (SYNC_STAGES < 0) begin : g_bad_sync
      $error("SYNC_STAGES must not be negative");
   end

   logic    settled_seen;
   logic    gap_done, tmo_done, restart;
   strobe_t strobes;

   if (SYNC_STAGES == 0) begin : g_direct
      assign settled_seen = body_at_gnd;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q, body_at_gnd} >> 0;
      end
      assign settled_seen = sync_q[SYNC_STAGES-1];
   end

   bbias_step_timer #(
      .GAP_CYCLES  (GAP_CYCLES),
      .WAKE_TIMEOUT(WAKE_TIMEOUT)
   ) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .gap_done(gap_done),
      .tmo_done(tmo_done)
   );

   bbias_seq_fsm u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .sleep_req   (sleep_req),
      .settled_seen(settled_seen),
      .gap_done    (gap_done),
      .tmo_done    (tmo_done),
      .restart     (restart),
      .strobes     (strobes)
   );

   assign amp_en_o    = strobes.amp_en;
   assign rbb_clamp_o = strobes.clamp;
   assign body_pull_o = strobes.pull;
   assign stable_o    = strobes.stable;

endmodule

// File: rtl/bbias_seq_chk.sv
module bbias_seq_chk #(
   parameter int WAKE_TIMEOUT = 4
) (
   input logic clk,
   input logic rst_n,
   input logic amp,
   input logic clamp,
   input logic pull,
   input logic stable
);
   localparam int RW = $clog2(WAKE_TIMEOUT + 2);

   // Length of the current pull pulse, counted independently of the design.
   logic [RW-1:0] run_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             run_q <= '0;
      else if (!pull)                         run_q <= '0;
      else if (run_q != RW'(WAKE_TIMEOUT + 1)) run_q <= run_q + 1'b1;
   end

   p_clamp_pull_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(clamp && pull));

   p_clamp_amp_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(clamp && amp));

   p_amp_off_before_clamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(clamp) |-> $past(!amp));

   p_no_pull_on_amp_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(amp) |-> !pull && !clamp);

   p_clamp_off_before_pull_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pull) |-> $past(!clamp));

   p_pull_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pull |-> (run_q < RW'(WAKE_TIMEOUT)));

   p_pull_off_before_amp_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(amp) |-> $past(!pull));

   p_stable_at_rest_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stable |-> ((amp && !clamp && !pull) || (clamp && !amp && !pull)));

endmodule

bind bbias_seq bbias_seq_chk #(.WAKE_TIMEOUT(WAKE_TIMEOUT)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .amp   (amp_en_o),
   .clamp (rbb_clamp_o),
   .pull  (body_pull_o),
   .stable(stable_o)
);

// File: tb/test_bbias_seq.sv
`timescale 1ns/1ps
module test_bbias_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sleep_req = 1'b1;
   logic body_at_gnd = 1'b0;
   logic amp_en_o, rbb_clamp_o, body_pull_o, stable_o;

   int  n_vec  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   bbias_seq #(.GAP_CYCLES(1), .WAKE_TIMEOUT(4), .SYNC_STAGES(0)) i_bbias_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .sleep_req  (sleep_req),
      .body_at_gnd(body_at_gnd),
      .amp_en_o   (amp_en_o),
      .rbb_clamp_o(rbb_clamp_o),
      .body_pull_o(body_pull_o),
      .stable_o   (stable_o)
   );

   // {req[3:0], sleep_req, body_at_gnd, exp amp, clamp, pull, stable}
   // outputs expected one edge after the inputs are applied
   localparam logic [9:0] VEC [24] = '{
      {4'd9,  2'b10, 4'b0101},  // R9 standby rest holds
      {4'd4,  2'b00, 4'b0000},  // R4 clamp drops first
      {4'd4,  2'b00, 4'b0010},  // R4 pull rises after gap
      {4'd5,  2'b00, 4'b0010},  // R5 pull held, no indication
      {4'd5,  2'b00, 4'b0010},
      {4'd5,  2'b00, 4'b0010},  // fourth pull cycle
      {4'd5,  2'b00, 4'b0000},  // R5 timeout ends pull
      {4'd6,  2'b00, 4'b1001},  // R6 amp after gap
      {4'd9,  2'b00, 4'b1001},  // R9 active rest
      {4'd2,  2'b10, 4'b0000},  // R2 amp drops first
      {4'd2,  2'b10, 4'b0101},  // R2 clamp after gap
      {4'd4,  2'b00, 4'b0000},
      {4'd4,  2'b00, 4'b0010},
      {4'd5,  2'b01, 4'b0000},  // R5 indication ends pull
      {4'd6,  2'b00, 4'b1001},
      {4'd2,  2'b10, 4'b0000},
      {4'd8,  2'b00, 4'b0101},  // R8 request flipped, down sequence finishes
      {4'd8,  2'b00, 4'b0000},  // then release
      {4'd8,  2'b10, 4'b0010},  // R8 up sequence continues
      {4'd8,  2'b11, 4'b0000},
      {4'd8,  2'b10, 4'b1001},  // reaches active rest
      {4'd2,  2'b10, 4'b0000},  // then goes down
      {4'd3,  2'b10, 4'b0101},  // R3 pull stayed low
      {4'd10, 2'b11, 4'b0101}   // R10 indication ignored at rest
   };

   function automatic logic [3:0] outs();
      return {amp_en_o, rbb_clamp_o, body_pull_o, stable_o};
   endfunction

   task automatic chk(input logic [3:0] got, input logic [3:0] exp, input int req, input string what);
      n_vec++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL R%0d %s: got amp/clamp/pull/stable=%b expected %b", req, what, got, exp);
      end
   endtask

   task automatic chk_excl();
      n_vec++;
      if ((rbb_clamp_o && body_pull_o) || (rbb_clamp_o && amp_en_o)) begin
         n_fail++;
         $display("FAIL R7 exclusion: got %b expected clamp alone", outs());
      end
   endtask

   task automatic step(input logic s, input logic g);
      @(negedge clk);
      sleep_req   = s;
      body_at_gnd = g;
      @(posedge clk);
      #1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 chk(outs(), 4'b0101, 1, "during reset");         // R1
      @(negedge clk) rst_n = 1'b1;
      #1 chk(outs(), 4'b0101, 1, "after release");        // R1

      for (int i = 0; i < 24; i++) begin
         step(VEC[i][5], VEC[i][4]);
         chk(outs(), VEC[i][3:0], int'(VEC[i][9:6]), $sformatf("vector %0d", i));
         chk_excl();
      end

      // R10/R5: indication already high from standby; release ignores it,
      // pull still lasts exactly one cycle.
      step(1'b0, 1'b1);
      chk(outs(), 4'b0000, 10, "release ignores indication");
      step(1'b0, 1'b1);
      chk(outs(), 4'b0010, 5, "minimum pull");
      step(1'b0, 1'b1);
      chk(outs(), 4'b0000, 5, "pull ends on indication");
      step(1'b0, 1'b1);
      chk(outs(), 4'b1001, 10, "active rest with indication high");

      // R1: asynchronous reset from active rest
      @(negedge clk) rst_n = 1'b0;
      #1 chk(outs(), 4'b0101, 1, "reset from active");
      @(negedge clk) begin rst_n = 1'b1; sleep_req = 1'b1; body_at_gnd = 1'b0; end
      @(posedge clk); #1;
      chk(outs(), 4'b0101, 1, "standby after reset");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         n_fail++;
         n_vec++;
         $display("FAIL watchdog: got no completion expected finish");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

endmodule